// File: doc/BRIEF.md
# Branch Target Pair Cache

The block is a small fully associative store that sits beside the fetch path. It remembers the first two instructions fetched after a taken branch and files them under that branch's logical address. When the same branch is taken again, the block returns both instructions on the next cycle. The issue queue can then be loaded with them straight away, without waiting for the instruction cache.

A taken branch is reported with `br_taken` and its address. The block compares that address against every valid tag in the same cycle and registers the result. On a miss it arms a pending allocation. The next two fetch words delivered with `fetch_valid` complete the allocation, and the pair lands in a free slot chosen by a pseudo-random sequence. A pulse on `flush_all` empties the whole store in one cycle.

Top module: `tgt_pair_cache`

## Requirements
- R1: After synchronous reset every entry is invalid, `hit_valid` is 0, and any lookup misses.
- R2: A `br_taken` sampled at a clock edge whose address equals a valid tag drives `hit_valid`=1 after that same edge. `hit_insn0` then shows the first stored word and `hit_insn1` the second.
- R3: A lookup that matches no valid tag gives `hit_valid`=0 after the edge and starts a pending allocation keyed by that address.
- R4: While an allocation is pending, the first cycle with `fetch_valid` after the branch cycle supplies word 0 and the second supplies word 1. A fetch word in the branch cycle itself is not captured. The entry becomes valid at the edge that captures word 1, and a lookup in the following cycle hits.
- R5: A new `br_taken` before word 1 is captured cancels the pending allocation, and the earlier address still misses afterwards.
- R6: A lookup that hits starts no allocation, and fetch words that follow it leave the stored pair unchanged.
- R7: While any entry is invalid, an allocation writes an invalid entry and never evicts a valid one. Thirty-two distinct addresses allocated into an empty store all hit afterwards.
- R8: With all entries valid, an allocation replaces exactly one entry. After a 33rd address is allocated, it hits and exactly 31 of the first 32 addresses still hit.
- R9: `flush_all` clears every valid bit in one cycle, cancels any pending allocation, and forces `hit_valid` to 0 for a lookup in the same cycle.
- R10: No two valid entries ever carry the same tag, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Invalidate every entry and drop a pending allocation |
| br_taken | input | 1 | Taken-branch event; starts a lookup |
| br_addr | input | ADDR_W | Logical address of the taken branch |
| fetch_valid | input | 1 | A fetched instruction is present on `fetch_insn` |
| fetch_insn | input | INSN_W | Fetched instruction word |
| hit_valid | output | 1 | Registered: the previous lookup hit |
| hit_insn0 | output | INSN_W | First stored instruction of the hit entry |
| hit_insn1 | output | INSN_W | Second stored instruction of the hit entry |

## Verification
Internal faults show up as the hit flag or the returned pair one cycle after a lookup. A valid bit that is lost or never set turns an expected hit into a miss. A wrong capture order or a missed cancellation shows as swapped or stale words on the next hit of that address. A victim chooser that ignores free slots causes silent evictions, which only appear when the full set of 32 addresses is probed again. For that reason the bench fills the store completely and counts hits across every tag.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  parameter int INSN_W = 32;

  typedef struct packed {
    logic [INSN_W-1:0] w0;
    logic [INSN_W-1:0] w1;
  } insn_pair_t;
endpackage

// File: rtl/tpc_lfsr.sv
module tpc_lfsr #(
  parameter int          WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8,
  parameter logic [WIDTH-1:0] SEED = 8'h5A
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEED;
    else     st_q <= (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
  end

  assign state_o = st_q;
endmodule

// File: rtl/tpc_match.sv
module tpc_match #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic [ENTRIES-1:0]             match_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == addr_i);
  end

  assign hit_o = |match_o;

  // Tags are unique, so OR-ing the indices of matching entries encodes the one hit.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/tpc_victim.sv
module tpc_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic [IDX_W-1:0]   slot_o,
  output logic               full_o
);
  logic found;

  // Scan from the random start, wrapping around; first free slot wins.
  always_comb begin
    slot_o = start_i;
    found  = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      int idx;
      idx = (int'(start_i) + k) % ENTRIES;
      if (!found && !valid_i[idx]) begin
        slot_o = IDX_W'(idx);
        found  = 1'b1;
      end
    end
  end

  assign full_o = &valid_i;
endmodule

// File: rtl/tgt_pair_cache.sv
module tgt_pair_cache
  import tpc_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int ADDR_W    = 32,
  parameter int LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_all,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              fetch_valid,
  input  logic [INSN_W-1:0] fetch_insn,
  output logic              hit_valid,
  output logic [INSN_W-1:0] hit_insn0,
  output logic [INSN_W-1:0] hit_insn1
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  insn_pair_t                     pair_mem [ENTRIES];
  insn_pair_t                     rd_q;

  logic              pend_q;
  logic              half_q;
  logic [ADDR_W-1:0] pend_tag_q;
  logic [INSN_W-1:0] first_q;
  logic              hit_q;

  logic [ENTRIES-1:0] match;
  logic               look_hit;
  logic [IDX_W-1:0]   look_idx;
  logic [LFSR_W-1:0]  lfsr;
  logic [IDX_W-1:0]   start_idx;
  logic [IDX_W-1:0]   slot;
  logic               full;
  logic               take_word;
  logic               wr_en;

  tpc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .valid_i(valid_q), .tags_i(tag_q), .addr_i(br_addr),
    .match_o(match), .hit_o(look_hit), .idx_o(look_idx)
  );

  tpc_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state_o(lfsr)
  );

  assign start_idx = IDX_W'(32'(lfsr) % ENTRIES);

  tpc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i(valid_q), .start_i(start_idx), .slot_o(slot), .full_o(full)
  );

  // Fetch words count only after the branch cycle and while nothing cancels.
  assign take_word = pend_q && fetch_valid && !br_taken && !flush_all;
  assign wr_en     = take_word && half_q;

  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      valid_q <= '0;
      pend_q  <= 1'b0;
      half_q  <= 1'b0;
    end else if (br_taken) begin
      pend_q <= !look_hit;
      half_q <= 1'b0;
    end else if (take_word) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else begin
        valid_q[slot] <= 1'b1;
        pend_q        <= 1'b0;
        half_q        <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (br_taken) pend_tag_q <= br_addr;
    if (take_word && !half_q) first_q <= fetch_insn;
    if (wr_en) tag_q[slot] <= pend_tag_q;
  end

  // Pair storage: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) pair_mem[slot] <= '{w0: first_q, w1: fetch_insn};
    rd_q <= pair_mem[look_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= br_taken && look_hit && !flush_all;
  end

  assign hit_valid = hit_q;
  assign hit_insn0 = rd_q.w0;
  assign hit_insn1 = rd_q.w1;

  AST_HIT_FROM_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(br_taken)); // R2
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R10
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full) |-> !valid_q[slot]); // R7
  AST_ALLOC_MARKS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(slot)]); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_q == '0 && !hit_valid && !pend_q)); // R9
  AST_HIT_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (br_taken && look_hit && !flush_all) |=> !pend_q); // R6
endmodule

// File: tb/sim_tgt_pair_cache.sv
module sim_tgt_pair_cache;
  localparam int ENTRIES = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_all = 1'b0;
  logic        br_taken = 1'b0;
  logic [31:0] br_addr = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_insn = '0;
  logic        hit_valid;
  logic [31:0] hit_insn0, hit_insn1;

  always #10 clk = ~clk;

  tgt_pair_cache u0 (
    .clk(clk), .rst(rst), .flush_all(flush_all), .br_taken(br_taken),
    .br_addr(br_addr), .fetch_valid(fetch_valid), .fetch_insn(fetch_insn),
    .hit_valid(hit_valid), .hit_insn0(hit_insn0), .hit_insn1(hit_insn1)
  );

  typedef struct {
    bit          count_only;
    bit          hit;
    logic [31:0] addr;
    string       req;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   hit_tally = 0;
  bit   lk_d = 1'b0;

  function automatic logic [31:0] word0(input logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 7);
  endfunction
  function automatic logic [31:0] word1(input logic [31:0] a);
    return ~a ^ 32'h1234_5678;
  endfunction

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) lk_d <= br_taken && !rst;

  // Monitor: one expected item per lookup, compared the cycle after it.
  always @(negedge clk) begin
    if (lk_d) begin
      if (expq.size() == 0) begin
        check(1'b0, "queue", 96'(hit_valid), 96'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (e.count_only) begin
          if (hit_valid) begin
            hit_tally++;
            check({hit_insn0, hit_insn1} == {word0(e.addr), word1(e.addr)}, e.req,
                  {32'(hit_valid), hit_insn0, hit_insn1}, {32'd1, word0(e.addr), word1(e.addr)});
          end
        end else if (e.hit) begin
          check(hit_valid && {hit_insn0, hit_insn1} == {word0(e.addr), word1(e.addr)}, e.req,
                {32'(hit_valid), hit_insn0, hit_insn1}, {32'd1, word0(e.addr), word1(e.addr)});
        end else begin
          check(!hit_valid, e.req, 96'(hit_valid), 96'd0);
        end
      end
    end
  end

  task automatic look(input logic [31:0] a, input bit hit, input bit cnt, input string req);
    exp_t e;
    @(negedge clk);
    br_taken = 1'b1;
    br_addr  = a;
    e.count_only = cnt; e.hit = hit; e.addr = a; e.req = req;
    expq.push_back(e);
    @(negedge clk);
    br_taken    = 1'b0;
    fetch_valid = 1'b0;
  endtask

  task automatic feed(input logic [31:0] w);
    fetch_valid = 1'b1;
    fetch_insn  = w;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  // Miss lookup followed by the two fetch words of the pair model.
  task automatic alloc(input logic [31:0] a, input string req);
    look(a, 1'b0, 1'b0, req);
    feed(word0(a));
    feed(word1(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(hit_valid == 1'b0, "R1", 96'(hit_valid), 96'd0);
    look(32'h0000_0100, 1'b0, 1'b0, "R1");

    // R4: a word present in the branch cycle itself is not captured
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_insn  = 32'hBAD0_BAD0;
    look(32'h0000_0200, 1'b0, 1'b0, "R3");
    feed(word0(32'h0000_0200));
    feed(word1(32'h0000_0200));
    look(32'h0000_0200, 1'b1, 1'b0, "R4");
    look(32'h0000_0200, 1'b1, 1'b0, "R2");

    // R6: fetch words after a hit must not overwrite the pair
    look(32'h0000_0200, 1'b1, 1'b0, "R6");
    feed(32'h1111_1111);
    feed(32'h2222_2222);
    look(32'h0000_0200, 1'b1, 1'b0, "R6");

    // R5: cancel after one word, then allocate a different address
    look(32'h0000_0300, 1'b0, 1'b0, "R5");
    feed(32'h3333_3333);
    alloc(32'h0000_0400, "R5");
    look(32'h0000_0400, 1'b1, 1'b0, "R5");
    look(32'h0000_0300, 1'b0, 1'b0, "R5");

    // R9: flush together with a lookup of a valid address
    @(negedge clk);
    flush_all = 1'b1;
    br_taken  = 1'b1;
    br_addr   = 32'h0000_0200;
    begin
      exp_t e;
      e.count_only = 1'b0; e.hit = 1'b0; e.addr = 32'h0000_0200; e.req = "R9";
      expq.push_back(e);
    end
    @(negedge clk);
    flush_all = 1'b0;
    br_taken  = 1'b0;
    look(32'h0000_0200, 1'b0, 1'b0, "R9");
    look(32'h0000_0400, 1'b0, 1'b0, "R9");
    // R9: flush drops a pending allocation
    look(32'h0000_0500, 1'b0, 1'b0, "R9");
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    feed(word0(32'h0000_0500));
    feed(word1(32'h0000_0500));
    look(32'h0000_0500, 1'b0, 1'b0, "R9");
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;

    // R7: fill every entry, then every address hits
    for (int i = 0; i < ENTRIES; i++) alloc(32'h0001_0000 + i * 4, "R7");
    for (int i = 0; i < ENTRIES; i++) look(32'h0001_0000 + i * 4, 1'b1, 1'b0, "R7");

    // R8: one more allocation evicts exactly one entry
    alloc(32'h0002_0000, "R8");
    look(32'h0002_0000, 1'b1, 1'b0, "R8");
    for (int i = 0; i < ENTRIES; i++) look(32'h0001_0000 + i * 4, 1'b0, 1'b1, "R8");
    repeat (3) @(negedge clk);
    check(hit_tally == ENTRIES - 1, "R8", 96'(hit_tally), 96'(ENTRIES - 1));
    check(expq.size() == 0, "queue", 96'(expq.size()), 96'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule